// File: doc/BRIEF.md
# Register Rename Stage with Undo History

This block renames a group of instructions each cycle for an out-of-order core with one thread. Each source operand is looked up in a table that maps architectural registers to physical registers. Each destination operand gets a fresh physical register taken from a free pool. The renamed group appears on registered outputs one cycle after it is accepted. A group is accepted whole or not at all. Upstream holds the group steady while either stall output is high.

Every destination rename writes one record into an ordered history: the instruction's sequence number, the architectural register, the new physical register and the physical register it displaced. A commit removes the oldest record that matches its sequence number and returns the displaced register to the pool. A squash walks the history from its youngest end. It undoes one record per cycle and returns each new register to the pool. No checkpoint copies of the table are kept.

Top module: `reg_rename_hist`

## Requirements
- R1: After reset, architectural register i maps to physical register i. The pool holds registers ARCH_REGS to PHYS_REGS-1 in ascending order. No output is valid and neither stall output is high.
- R2: A group of up to GROUP instructions is accepted in one cycle. Slot 0 is the oldest. The renamed group shows on the outputs, with its sequence numbers and slot valids, one clock edge after acceptance.
- R3: A source lookup returns the current mapping. That mapping includes any destination renamed by an older slot of the same group and any earlier group.
- R4: Destinations take registers from the head of the pool in slot order. The displaced-register output gives the mapping that was current just before that slot, including older slots of the same group.
- R5: Only an instruction that writes a destination creates a history record and uses a pool register. A group without destinations is accepted even when the pool is empty and the history is full.
- R6: When the pool holds fewer registers than the group has destinations, stall_noreg is high and nothing of the group is renamed.
- R7: When the history has fewer free slots than the group has destinations, busy is high and nothing of the group is renamed.
- R8: A squash undoes records one per clock, youngest first. For each record it writes the displaced register back into the table and appends the new register to the pool. The walk stops at the first record whose sequence number is not younger than the squash number. Younger means a nonzero wrap-around difference with a clear top bit. busy is high during the walk. Instructions offered in the squash cycle or during the walk are not renamed.
- R9: A commit whose sequence number equals the oldest record removes that record and appends its displaced register to the pool. A commit that matches no record has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | GROUP | Slot valid, slot 0 oldest |
| in_seq | input | GROUP x SEQ_W | Sequence number per slot |
| in_src1 | input | GROUP x AW | First architectural source |
| in_src2 | input | GROUP x AW | Second architectural source |
| in_has_dst | input | GROUP | Slot writes a destination |
| in_dst | input | GROUP x AW | Architectural destination |
| out_valid | output | GROUP | Renamed slot valid |
| out_seq | output | GROUP x SEQ_W | Sequence number of renamed slot |
| out_psrc1 | output | GROUP x PW | Physical first source |
| out_psrc2 | output | GROUP x PW | Physical second source |
| out_has_dst | output | GROUP | Renamed slot writes a destination |
| out_pdst | output | GROUP x PW | New physical destination |
| out_pold | output | GROUP x PW | Displaced physical register |
| cmt_valid | input | 1 | Commit request |
| cmt_seq | input | SEQ_W | Sequence number being committed |
| sq_valid | input | 1 | Squash request |
| sq_seq | input | SEQ_W | Youngest surviving sequence number |
| stall_noreg | output | 1 | Pool lacks registers for the offered group |
| busy | output | 1 | Squash walk in progress or history lacks room |

## Verification
The embedded assertions watch, on every cycle, that the pool never gives out more registers than it holds and never exceeds its reset size. They also check that the history never overfills or pops when empty, that a squash cycle, an undo walk or a register stall is followed by an empty output group, and that a renamed destination never equals the register it displaced. Only the directed scenarios show the mapping values themselves: in-group forwarding, the order in which registers come back to the pool after commit and squash, the exact length of an undo walk, and acceptance of destination-free groups while resources are exhausted.

// File: rtl/rn_pkg.sv
// Shared definitions for the rename stage.
package rn_pkg;
    // Control mode: normal renaming or undoing history after a squash.
    typedef enum logic {
        RN_RUN  = 1'b0,
        RN_UNDO = 1'b1
    } rn_mode_e;
endpackage

// File: rtl/rn_free_list.sv
// Circular pool of free physical registers.
// Hands out up to GROUP registers per cycle from the head and takes back up
// to two per cycle at the tail (commit release first, then undo release).
// Assumes PHYS_REGS is a power of two and the caller never pops more than
// the count it sees.
module rn_free_list #(
    parameter int PHYS_REGS = 16,
    parameter int ARCH_REGS = 8,
    parameter int GROUP     = 2,
    localparam int PW = $clog2(PHYS_REGS),
    localparam int CW = $clog2(PHYS_REGS + 1),
    localparam int NW = $clog2(GROUP + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NW-1:0]            pop_cnt,
    output logic [GROUP-1:0][PW-1:0] head_ids,
    output logic [CW-1:0]            free_cnt,
    input  logic                     push_a_v,
    input  logic [PW-1:0]            push_a,
    input  logic                     push_b_v,
    input  logic [PW-1:0]            push_b
);
    localparam int INIT = PHYS_REGS - ARCH_REGS;

    logic [PW-1:0] slots [PHYS_REGS];
    logic [PW-1:0] rd_ptr;
    logic [PW-1:0] wr_ptr;
    logic [CW-1:0] cnt;

    // Expose the next GROUP candidates at the head.
    always_comb begin
        for (int k = 0; k < GROUP; k++) begin
            head_ids[k] = slots[rd_ptr + PW'(k)];
        end
    end

    assign free_cnt = cnt;

    // Pool storage, pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < PHYS_REGS; i++) begin
                slots[i] <= (i < INIT) ? PW'(ARCH_REGS + i) : '0;
            end
            rd_ptr <= '0;
            wr_ptr <= PW'(INIT);
            cnt    <= CW'(INIT);
        end else begin
            if (push_a_v) slots[wr_ptr] <= push_a;
            if (push_b_v) slots[wr_ptr + PW'(push_a_v)] <= push_b;
            rd_ptr <= rd_ptr + PW'(pop_cnt);
            wr_ptr <= wr_ptr + PW'(push_a_v) + PW'(push_b_v);
            cnt    <= cnt - CW'(pop_cnt) + CW'(push_a_v) + CW'(push_b_v);
        end
    end

    // R6: never hand out more registers than the pool holds.
    p_fl_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        CW'(pop_cnt) <= cnt);
    // R1: the pool never holds more than its reset population.
    p_fl_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(INIT));
endmodule

// File: rtl/rn_history.sv
// Ordered circular history of destination renames.
// Appends compacted records at the young end, removes the oldest on commit
// and the youngest on undo. Assumes DEPTH is a power of two and that the
// caller checks room before appending.
module rn_history #(
    parameter int DEPTH = 8,
    parameter int GROUP = 2,
    parameter int SEQ_W = 8,
    parameter int AW    = 3,
    parameter int PW    = 4,
    localparam int HW  = $clog2(DEPTH),
    localparam int HCW = $clog2(DEPTH + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [GROUP-1:0]            push_v,
    input  logic [GROUP-1:0][SEQ_W-1:0] push_seq,
    input  logic [GROUP-1:0][AW-1:0]    push_arch,
    input  logic [GROUP-1:0][PW-1:0]    push_new,
    input  logic [GROUP-1:0][PW-1:0]    push_old,
    input  logic                        pop_head,
    input  logic                        pop_tail,
    output logic [SEQ_W-1:0]            head_seq,
    output logic [PW-1:0]               head_old,
    output logic [SEQ_W-1:0]            tail_seq,
    output logic [AW-1:0]               tail_arch,
    output logic [PW-1:0]               tail_new,
    output logic [PW-1:0]               tail_old,
    output logic [HCW-1:0]              count
);
    logic [SEQ_W-1:0] e_seq  [DEPTH];
    logic [AW-1:0]    e_arch [DEPTH];
    logic [PW-1:0]    e_new  [DEPTH];
    logic [PW-1:0]    e_old  [DEPTH];

    logic [HW-1:0]  rd_ptr;
    logic [HW-1:0]  wr_ptr;
    logic [HW-1:0]  tail_idx;
    logic [HCW-1:0] cnt;
    logic [HCW-1:0] push_n;
    logic [HW-1:0]  push_idx [GROUP];

    // Place each appended record right after the previous valid one.
    always_comb begin
        logic [HCW-1:0] acc;
        acc = '0;
        for (int k = 0; k < GROUP; k++) begin
            push_idx[k] = wr_ptr + acc[HW-1:0];
            acc = acc + HCW'(push_v[k]);
        end
        push_n = acc;
    end

    assign tail_idx  = wr_ptr - HW'(1);
    assign head_seq  = e_seq[rd_ptr];
    assign head_old  = e_old[rd_ptr];
    assign tail_seq  = e_seq[tail_idx];
    assign tail_arch = e_arch[tail_idx];
    assign tail_new  = e_new[tail_idx];
    assign tail_old  = e_old[tail_idx];
    assign count     = cnt;

    // Record storage; contents need no reset.
    always_ff @(posedge clk) begin
        for (int k = 0; k < GROUP; k++) begin
            if (push_v[k]) begin
                e_seq[push_idx[k]]  <= push_seq[k];
                e_arch[push_idx[k]] <= push_arch[k];
                e_new[push_idx[k]]  <= push_new[k];
                e_old[push_idx[k]]  <= push_old[k];
            end
        end
    end

    // Pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= '0;
        end else begin
            rd_ptr <= rd_ptr + HW'(pop_head);
            wr_ptr <= wr_ptr + push_n[HW-1:0] - HW'(pop_tail);
            cnt    <= cnt + push_n - HCW'(pop_head) - HCW'(pop_tail);
        end
    end

    // R7: appends never exceed the free history slots.
    p_hist_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, cnt} + {1'b0, push_n}) <= (HCW+1)'(DEPTH));
    // R9: a removal only happens on a non-empty history.
    p_hist_pop_nonempty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_head || pop_tail) |-> (cnt != '0));
    // R8: commit and undo never remove the same last record.
    p_hist_dual_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_head && pop_tail) |-> (cnt >= HCW'(2)));
endmodule

// File: rtl/rn_map.sv
// Architectural-to-physical mapping table with in-group forwarding.
// Computes source, new and displaced registers for all slots of a group in
// one pass, letting older slots' destinations feed younger slots' lookups.
// Assumes group writes and undo restores never occur in the same cycle.
module rn_map #(
    parameter int ARCH_REGS = 8,
    parameter int PHYS_REGS = 16,
    parameter int GROUP     = 2,
    localparam int AW = $clog2(ARCH_REGS),
    localparam int PW = $clog2(PHYS_REGS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [GROUP-1:0]         slot_v,
    input  logic [GROUP-1:0]         slot_hd,
    input  logic [GROUP-1:0][AW-1:0] slot_dst,
    input  logic [GROUP-1:0][AW-1:0] slot_src1,
    input  logic [GROUP-1:0][AW-1:0] slot_src2,
    input  logic [GROUP-1:0][PW-1:0] free_ids,
    input  logic                     grp_we,
    input  logic                     undo_v,
    input  logic [AW-1:0]            undo_arch,
    input  logic [PW-1:0]            undo_phys,
    output logic [GROUP-1:0][PW-1:0] ps1,
    output logic [GROUP-1:0][PW-1:0] ps2,
    output logic [GROUP-1:0][PW-1:0] pd,
    output logic [GROUP-1:0][PW-1:0] pold
);
    logic [PW-1:0] tbl [ARCH_REGS];
    logic [PW-1:0] run [ARCH_REGS];

    // Rename slots in age order against a running copy of the table.
    always_comb begin
        int rank;
        logic [PW-1:0] pick;
        run  = tbl;
        rank = 0;
        for (int k = 0; k < GROUP; k++) begin
            pick = '0;
            for (int j = 0; j < GROUP; j++) begin
                if (j == rank) pick = free_ids[j];
            end
            ps1[k]  = run[slot_src1[k]];
            ps2[k]  = run[slot_src2[k]];
            pd[k]   = '0;
            pold[k] = '0;
            if (slot_v[k] && slot_hd[k]) begin
                pold[k] = run[slot_dst[k]];
                pd[k]   = pick;
                run[slot_dst[k]] = pick;
                rank = rank + 1;
            end
        end
    end

    // Table update: whole group on accept, single entry on undo.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ARCH_REGS; i++) begin
                tbl[i] <= PW'(i);
            end
        end else if (grp_we) begin
            tbl <= run;
        end else if (undo_v) begin
            tbl[undo_arch] <= undo_phys;
        end
    end

    // R8: group writes and undo restores are exclusive.
    p_map_one_writer_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(grp_we && undo_v));
endmodule

// File: rtl/reg_rename_hist.sv
// Register rename stage, one thread, history-based recovery.
// Accepts a whole group when the pool and the history both have room,
// registers the renamed group, releases registers on commit and undoes
// younger history records one per cycle after a squash.
// Assumes upstream holds a stalled group and commits arrive in age order.
module reg_rename_hist #(
    parameter int ARCH_REGS  = 8,
    parameter int PHYS_REGS  = 16,
    parameter int GROUP      = 2,
    parameter int HIST_DEPTH = 8,
    parameter int SEQ_W      = 8,
    localparam int AW = $clog2(ARCH_REGS),
    localparam int PW = $clog2(PHYS_REGS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [GROUP-1:0]            in_valid,
    input  logic [GROUP-1:0][SEQ_W-1:0] in_seq,
    input  logic [GROUP-1:0][AW-1:0]    in_src1,
    input  logic [GROUP-1:0][AW-1:0]    in_src2,
    input  logic [GROUP-1:0]            in_has_dst,
    input  logic [GROUP-1:0][AW-1:0]    in_dst,
    output logic [GROUP-1:0]            out_valid,
    output logic [GROUP-1:0][SEQ_W-1:0] out_seq,
    output logic [GROUP-1:0][PW-1:0]    out_psrc1,
    output logic [GROUP-1:0][PW-1:0]    out_psrc2,
    output logic [GROUP-1:0]            out_has_dst,
    output logic [GROUP-1:0][PW-1:0]    out_pdst,
    output logic [GROUP-1:0][PW-1:0]    out_pold,
    input  logic                        cmt_valid,
    input  logic [SEQ_W-1:0]            cmt_seq,
    input  logic                        sq_valid,
    input  logic [SEQ_W-1:0]            sq_seq,
    output logic                        stall_noreg,
    output logic                        busy
);
    import rn_pkg::*;

    localparam int FCW = $clog2(PHYS_REGS + 1);
    localparam int HCW = $clog2(HIST_DEPTH + 1);
    localparam int NW  = $clog2(GROUP + 1);

    rn_mode_e                  mode;
    logic [SEQ_W-1:0]          sq_tgt;
    logic [NW-1:0]             need;
    logic [GROUP-1:0]          dst_mask;
    logic [FCW-1:0]            fl_cnt;
    logic [HCW-1:0]            hist_cnt;
    logic [GROUP-1:0][PW-1:0]  fl_heads;
    logic                      regs_short;
    logic                      hist_short;
    logic                      accept;
    logic                      undoing;
    logic                      commit_pop;
    logic                      walk_hit;
    logic [SEQ_W-1:0]          h_seq;
    logic [PW-1:0]             h_old;
    logic [SEQ_W-1:0]          t_seq;
    logic [AW-1:0]             t_arch;
    logic [PW-1:0]             t_new;
    logic [PW-1:0]             t_old;
    logic [GROUP-1:0][PW-1:0]  m_ps1;
    logic [GROUP-1:0][PW-1:0]  m_ps2;
    logic [GROUP-1:0][PW-1:0]  m_pd;
    logic [GROUP-1:0][PW-1:0]  m_pold;

    // True when a is strictly younger than b under wrap-around.
    function automatic logic seq_younger(input logic [SEQ_W-1:0] a,
                                         input logic [SEQ_W-1:0] b);
        logic [SEQ_W-1:0] d;
        d = a - b;
        return (d != '0) && !d[SEQ_W-1];
    endfunction

    // Count destinations in the offered group.
    always_comb begin
        need = '0;
        for (int k = 0; k < GROUP; k++) begin
            dst_mask[k] = in_valid[k] && in_has_dst[k];
            need = need + NW'(dst_mask[k]);
        end
    end

    // Resource checks, acceptance and stall outputs.
    always_comb begin
        undoing     = (mode == RN_UNDO);
        regs_short  = int'(need) > int'(fl_cnt);
        hist_short  = int'(need) > (HIST_DEPTH - int'(hist_cnt));
        accept      = (|in_valid) && !undoing && !sq_valid && !regs_short && !hist_short;
        stall_noreg = (|in_valid) && !undoing && regs_short;
        busy        = undoing || ((|in_valid) && hist_short);
    end

    // Commit and undo decisions against the history ends.
    always_comb begin
        commit_pop = cmt_valid && (hist_cnt != '0) && (h_seq == cmt_seq);
        walk_hit   = undoing && (hist_cnt != '0) && seq_younger(t_seq, sq_tgt)
                     && !(commit_pop && (hist_cnt == HCW'(1)));
    end

    // Mode: enter undo on squash, leave when the youngest record survives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode   <= RN_RUN;
            sq_tgt <= '0;
        end else if (sq_valid) begin
            mode   <= RN_UNDO;
            sq_tgt <= sq_seq;
        end else if (undoing && !walk_hit) begin
            mode   <= RN_RUN;
        end
    end

    rn_free_list #(
        .PHYS_REGS (PHYS_REGS),
        .ARCH_REGS (ARCH_REGS),
        .GROUP     (GROUP)
    ) u_pool (
        .clk      (clk),
        .rst_n    (rst_n),
        .pop_cnt  (accept ? need : NW'(0)),
        .head_ids (fl_heads),
        .free_cnt (fl_cnt),
        .push_a_v (commit_pop),
        .push_a   (h_old),
        .push_b_v (walk_hit),
        .push_b   (t_new)
    );

    rn_history #(
        .DEPTH (HIST_DEPTH),
        .GROUP (GROUP),
        .SEQ_W (SEQ_W),
        .AW    (AW),
        .PW    (PW)
    ) u_hist (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_v    (accept ? dst_mask : '0),
        .push_seq  (in_seq),
        .push_arch (in_dst),
        .push_new  (m_pd),
        .push_old  (m_pold),
        .pop_head  (commit_pop),
        .pop_tail  (walk_hit),
        .head_seq  (h_seq),
        .head_old  (h_old),
        .tail_seq  (t_seq),
        .tail_arch (t_arch),
        .tail_new  (t_new),
        .tail_old  (t_old),
        .count     (hist_cnt)
    );

    rn_map #(
        .ARCH_REGS (ARCH_REGS),
        .PHYS_REGS (PHYS_REGS),
        .GROUP     (GROUP)
    ) u_map (
        .clk       (clk),
        .rst_n     (rst_n),
        .slot_v    (in_valid),
        .slot_hd   (in_has_dst),
        .slot_dst  (in_dst),
        .slot_src1 (in_src1),
        .slot_src2 (in_src2),
        .free_ids  (fl_heads),
        .grp_we    (accept),
        .undo_v    (walk_hit),
        .undo_arch (t_arch),
        .undo_phys (t_old),
        .ps1       (m_ps1),
        .ps2       (m_ps2),
        .pd        (m_pd),
        .pold      (m_pold)
    );

    // Output valids: the accepted slots, else nothing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= '0;
        end else begin
            out_valid <= accept ? in_valid : '0;
        end
    end

    // Output payload, captured only on accept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_seq     <= '0;
            out_psrc1   <= '0;
            out_psrc2   <= '0;
            out_has_dst <= '0;
            out_pdst    <= '0;
            out_pold    <= '0;
        end else if (accept) begin
            out_seq     <= in_seq;
            out_psrc1   <= m_ps1;
            out_psrc2   <= m_ps2;
            out_has_dst <= dst_mask;
            out_pdst    <= m_pd;
            out_pold    <= m_pold;
        end
    end

    // R8: an undo cycle renames nothing.
    p_undo_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == RN_UNDO) |=> (out_valid == '0));
    // R8: the squash cycle itself renames nothing.
    p_squash_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sq_valid |=> (out_valid == '0));
    // R6: a register shortage renames nothing.
    p_noreg_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stall_noreg |=> (out_valid == '0));

    for (genvar g = 0; g < GROUP; g++) begin : g_slot_chk
        // R4: a fresh register never equals the one it displaces.
        p_new_differs_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid[g] && out_has_dst[g]) |-> (out_pdst[g] != out_pold[g]));
    end
endmodule

// File: tb/tb_reg_rename_hist.sv
module tb_reg_rename_hist;
    localparam int CLK_PERIOD = 10;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [1:0]       in_valid;
    logic [1:0][7:0]  in_seq;
    logic [1:0][2:0]  in_src1;
    logic [1:0][2:0]  in_src2;
    logic [1:0]       in_has_dst;
    logic [1:0][2:0]  in_dst;
    logic [1:0]       out_valid;
    logic [1:0][7:0]  out_seq;
    logic [1:0][3:0]  out_psrc1;
    logic [1:0][3:0]  out_psrc2;
    logic [1:0]       out_has_dst;
    logic [1:0][3:0]  out_pdst;
    logic [1:0][3:0]  out_pold;
    logic             cmt_valid;
    logic [7:0]       cmt_seq;
    logic             sq_valid;
    logic [7:0]       sq_seq;
    logic             stall_noreg;
    logic             busy;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    reg_rename_hist dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_seq(in_seq), .in_src1(in_src1), .in_src2(in_src2),
        .in_has_dst(in_has_dst), .in_dst(in_dst),
        .out_valid(out_valid), .out_seq(out_seq), .out_psrc1(out_psrc1),
        .out_psrc2(out_psrc2), .out_has_dst(out_has_dst), .out_pdst(out_pdst),
        .out_pold(out_pold),
        .cmt_valid(cmt_valid), .cmt_seq(cmt_seq), .sq_valid(sq_valid), .sq_seq(sq_seq),
        .stall_noreg(stall_noreg), .busy(busy)
    );

    task automatic chk(input string req, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s got=%0d exp=%0d", req, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_in();
        in_valid = '0; in_seq = '0; in_src1 = '0; in_src2 = '0;
        in_has_dst = '0; in_dst = '0;
    endtask

    task automatic set_slot(input int k, input int seq, input int s1, input int s2,
                            input bit hd, input int d);
        in_valid[k]   = 1'b1;
        in_seq[k]     = 8'(seq);
        in_src1[k]    = 3'(s1);
        in_src2[k]    = 3'(s2);
        in_has_dst[k] = hd;
        in_dst[k]     = 3'(d);
    endtask

    task automatic t_reset();
        chk("R1 out_valid", int'(out_valid), 0);
        chk("R1 stall_noreg", int'(stall_noreg), 0);
        chk("R1 busy", int'(busy), 0);
    endtask

    task automatic t_first_group();
        set_slot(0, 1, 1, 2, 1'b1, 3);
        set_slot(1, 2, 3, 4, 1'b1, 3);
        step();
        clear_in();
        chk("R2 out_valid", int'(out_valid), 3);
        chk("R2 seq0", int'(out_seq[0]), 1);
        chk("R2 seq1", int'(out_seq[1]), 2);
        chk("R1 identity src1", int'(out_psrc1[0]), 1);
        chk("R1 identity src2", int'(out_psrc2[0]), 2);
        chk("R3 in-group forward", int'(out_psrc1[1]), 8);
        chk("R3 plain src", int'(out_psrc2[1]), 4);
        chk("R4 pdst0", int'(out_pdst[0]), 8);
        chk("R4 pold0", int'(out_pold[0]), 3);
        chk("R4 pdst1", int'(out_pdst[1]), 9);
        chk("R4 pold1 in-group", int'(out_pold[1]), 8);
    endtask

    task automatic t_mixed_group();
        set_slot(0, 3, 3, 0, 1'b0, 0);
        set_slot(1, 4, 0, 1, 1'b1, 5);
        step();
        clear_in();
        chk("R3 cross-group src", int'(out_psrc1[0]), 9);
        chk("R5 no-dst flag", int'(out_has_dst[0]), 0);
        chk("R4 pdst after no-dst slot", int'(out_pdst[1]), 10);
        chk("R4 pold", int'(out_pold[1]), 5);
    endtask

    task automatic t_squash();
        int busy_cycles = 0;
        sq_valid = 1'b1; sq_seq = 8'd1;
        set_slot(0, 90, 0, 0, 1'b1, 7);
        step();
        sq_valid = 1'b0;
        chk("R8 squash-cycle group dropped", int'(out_valid), 0);
        chk("R8 busy during walk", int'(busy), 1);
        for (int i = 0; i < 10 && busy; i++) begin
            busy_cycles++;
            step();
        end
        chk("R8 walk length two records", busy_cycles, 3);
        clear_in();
        set_slot(0, 5, 3, 5, 1'b1, 6);
        step();
        clear_in();
        chk("R8 restored arch3", int'(out_psrc1[0]), 8);
        chk("R8 restored arch5", int'(out_psrc2[0]), 5);
        chk("R8 pool order after undo", int'(out_pdst[0]), 11);
        chk("R8 pold", int'(out_pold[0]), 6);
    endtask

    task automatic t_commit_exhaust();
        // R9: seq 3 has no record; nothing changes.
        cmt_valid = 1'b1; cmt_seq = 8'd3;
        step();
        cmt_seq = 8'd1;
        step();
        cmt_valid = 1'b0;
        set_slot(0, 6, 0, 0, 1'b1, 0);
        set_slot(1, 7, 0, 0, 1'b1, 1);
        step();
        chk("R4 pdst seq6", int'(out_pdst[0]), 12);
        chk("R4 pdst seq7", int'(out_pdst[1]), 13);
        set_slot(0, 8, 0, 0, 1'b1, 2);
        set_slot(1, 9, 0, 0, 1'b1, 4);
        step();
        chk("R4 pdst seq8", int'(out_pdst[0]), 14);
        chk("R4 pdst seq9", int'(out_pdst[1]), 15);
        set_slot(0, 10, 0, 0, 1'b1, 7);
        set_slot(1, 11, 0, 0, 1'b1, 0);
        step();
        clear_in();
        chk("R8 undo-freed reg reused", int'(out_pdst[0]), 10);
        chk("R8 undo-freed reg reused 2", int'(out_pdst[1]), 9);
        chk("R4 pold across groups", int'(out_pold[1]), 12);
        set_slot(0, 12, 0, 0, 1'b1, 1);
        step();
        clear_in();
        chk("R9 committed reg reused", int'(out_pdst[0]), 3);
        chk("R4 pold seq12", int'(out_pold[0]), 13);
        set_slot(0, 13, 2, 0, 1'b1, 2);
        cmt_valid = 1'b1; cmt_seq = 8'd5;
        #1;
        chk("R6 stall_noreg when pool empty", int'(stall_noreg), 1);
        chk("R7 busy when history full", int'(busy), 1);
        step();
        cmt_valid = 1'b0;
        chk("R6 nothing renamed on stall", int'(out_valid), 0);
        #1;
        chk("R6 stall clears after release", int'(stall_noreg), 0);
        step();
        clear_in();
        chk("R6 held group accepted", int'(out_valid), 1);
        chk("R9 commit released old reg", int'(out_pdst[0]), 6);
        chk("R4 pold seq13", int'(out_pold[0]), 14);
        // R5: pool empty and history full, yet no-dst group passes.
        set_slot(0, 14, 2, 7, 1'b0, 0);
        set_slot(1, 15, 1, 0, 1'b0, 0);
        #1;
        chk("R5 no stall for no-dst group", int'(stall_noreg), 0);
        chk("R5 not busy for no-dst group", int'(busy), 0);
        step();
        clear_in();
        chk("R5 no-dst group accepted", int'(out_valid), 3);
        chk("R3 src after full pool", int'(out_psrc1[0]), 6);
        chk("R3 src arch7", int'(out_psrc2[0]), 10);
        chk("R3 src arch1", int'(out_psrc1[1]), 3);
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        clear_in();
        cmt_valid = 1'b0; cmt_seq = '0;
        sq_valid = 1'b0; sq_seq = '0;
        @(negedge clk);
        step();
        rst_n = 1'b1;
        t_reset();
        t_first_group();
        t_mixed_group();
        t_squash();
        t_commit_exhaust();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule